// File: doc/BRIEF.md
# Dual-Target Interrupt Priority Arbiter

This block picks, for each of two processors, the most urgent pending interrupt among a set of request sources, and tells that processor whether it must be interrupted and which source to service. The sources are eight software-raised interrupts, held in a pending register driven by per-bit set and clear strobes, and a parameterized number of peripheral request lines. Each source carries a 4-bit priority and a one-bit route that sends it to processor 0 or processor 1.

For each processor the arbiter looks only at the asserted sources routed to it. It finds their highest priority and resolves ties toward the smallest source number. It encodes the winner as a 9-bit vector. An interrupt request is raised only when that priority is strictly greater than the processor's current priority input. The path is a fixed four-stage pipeline, so every request reaches the outputs with the same latency.

Top module: `darb_top`

## Requirements
- R1: Software source i (0..7) is reported as vector i, and peripheral line j is reported as vector 8+j; while an interrupt request output is high, its vector is below 8+NUM_PERIPH.
- R2: Bit k of `src_cpu` routes source k (bit 0 = processor 0, bit 1 = processor 1); a source never competes for the other processor.
- R3: Among the asserted sources routed to a processor, the one with the numerically largest 4-bit priority (bits 4k+3..4k of `src_prio` for source k) wins.
- R4: When several routed asserted sources share the largest priority, the lowest vector wins, whatever the order in which they became asserted.
- R5: A processor's interrupt output goes high only when the winning priority is strictly greater than that processor's current priority; equal does not interrupt.
- R6: A source with priority 0 never raises an interrupt output.
- R7: A software set strobe sampled at clock edge n, or a peripheral line sampled high at edge n, shows up on the interrupt outputs after edge n+3; priority and route are sampled at edge n+1 and the current priority at edge n+3.
- R8: While an interrupt output is low its vector output is 0; while it is high the vector is the winner's vector.
- R9: A software clear strobe drops that pending bit, a set strobe raises it, set wins when both arrive in the same cycle, and with neither the bit holds.
- R10: The synchronous active-high reset clears the pending register, the pipeline and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_set | input | 8 | Set strobes for the software pending bits |
| sw_clr | input | 8 | Clear strobes for the software pending bits |
| periph_req | input | NUM_PERIPH | Peripheral request levels |
| src_prio | input | 4*(8+NUM_PERIPH) | 4-bit priority per source, source k in bits 4k+3..4k |
| src_cpu | input | 8+NUM_PERIPH | Processor route per source |
| cur_prio0 | input | 4 | Current priority of processor 0 |
| cur_prio1 | input | 4 | Current priority of processor 1 |
| irq0 | output | 1 | Interrupt request to processor 0 |
| vec0 | output | 9 | Winning vector for processor 0 |
| irq1 | output | 1 | Interrupt request to processor 1 |
| vec1 | output | 9 | Winning vector for processor 1 |

## Verification
Random priorities, routes and sparse request bursts test the maximum search and routing against an independent model. Phases where every source has the same priority test only the tie-break. Directed cases cover the four-cycle latency from a set strobe and from a peripheral line, set-beats-clear, and the equal-to-current boundary. Other directed cases cover priority-zero sources and a late-arriving lower vector that must take over from an earlier higher one.

// File: rtl/darb_pkg.sv
package darb_pkg;
  localparam int SW_SRC = 8;
  localparam int CPU_N  = 2;
endpackage

// File: rtl/darb_swi_pend.sv
module darb_swi_pend #(
  parameter int SW_N = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_N-1:0] set_i,
  input  logic [SW_N-1:0] clr_i,
  output logic [SW_N-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o & ~clr_i) | set_i;
  end

  // R9: a set strobe always lands, even with a clear in the same cycle
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_o & $past(set_i)) == $past(set_i)));

  // R9: a lone clear empties the bit
  p_clr_drops_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/darb_max_stage.sv
module darb_max_stage #(
  parameter int N      = 32,
  parameter int PRIO_W = 4,
  parameter bit CPU_ID = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  input  logic [N-1:0]        route_i,
  output logic [PRIO_W-1:0]   max_q,
  output logic [N-1:0]        hit_q
);
  logic [N-1:0]      mine;
  logic [PRIO_W-1:0] max_c;
  logic [N-1:0]      hit_c;

  always_comb begin
    mine = CPU_ID ? (req_i & route_i) : (req_i & ~route_i);
    max_c = '0;
    for (int i = 0; i < N; i++) begin
      if (mine[i] && (prio_i[i*PRIO_W +: PRIO_W] > max_c))
        max_c = prio_i[i*PRIO_W +: PRIO_W];
    end
    for (int i = 0; i < N; i++)
      hit_c[i] = mine[i] && (prio_i[i*PRIO_W +: PRIO_W] == max_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= '0;
      hit_q <= '0;
    end else begin
      max_q <= max_c;
      hit_q <= hit_c;
    end
  end

  logic [N-1:0] route_m;
  assign route_m = CPU_ID ? route_i : ~route_i;

  // R2: every candidate left after the max search was routed here
  p_hit_routed_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((hit_q & ~$past(route_m)) == '0));

  // R2: candidates were asserted requests
  p_hit_requested_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((hit_q & ~$past(req_i)) == '0));
endmodule

// File: rtl/darb_pick_stage.sv
module darb_pick_stage #(
  parameter int N      = 32,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      hit_i,
  input  logic [PRIO_W-1:0] max_i,
  output logic              valid_q,
  output logic [PRIO_W-1:0] prio_q,
  output logic [VEC_W-1:0]  vec_q
);
  logic [VEC_W-1:0] sel_c;

  always_comb begin
    sel_c = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_i[i]) sel_c = VEC_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      prio_q  <= '0;
      vec_q   <= '0;
    end else begin
      valid_q <= |hit_i;
      prio_q  <= max_i;
      vec_q   <= sel_c;
    end
  end

  logic [N-1:0] below_m;
  assign below_m = (N'(1) << vec_q) - N'(1);

  // R4: no candidate with a smaller vector was passed over
  p_tie_lowest_r4: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (($past(hit_i) & below_m) == '0));

  // R4: the chosen vector was itself a candidate
  p_pick_member_r4: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((($past(hit_i) >> vec_q) & N'(1)) != '0));
endmodule

// File: rtl/darb_cmp_stage.sv
module darb_cmp_stage #(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [PRIO_W-1:0] cur_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic fire;
  assign fire = valid_i && (prio_i > cur_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= fire;
      vec_o <= fire ? vec_i : '0;
    end
  end

  // R6: a priority-0 winner cannot interrupt
  p_zero_prio_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(prio_i) != '0));
endmodule

// File: rtl/darb_top.sv
module darb_top
  import darb_pkg::*;
#(
  parameter int NUM_PERIPH = 24,
  parameter int PRIO_W     = 4,
  parameter int VEC_W      = 9,
  localparam int N         = SW_SRC + NUM_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SW_SRC-1:0]     sw_set,
  input  logic [SW_SRC-1:0]     sw_clr,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [N*PRIO_W-1:0]   src_prio,
  input  logic [N-1:0]          src_cpu,
  input  logic [PRIO_W-1:0]     cur_prio0,
  input  logic [PRIO_W-1:0]     cur_prio1,
  output logic                  irq0,
  output logic [VEC_W-1:0]      vec0,
  output logic                  irq1,
  output logic [VEC_W-1:0]      vec1
);
  logic [SW_SRC-1:0]     sw_pend;
  logic [NUM_PERIPH-1:0] periph_q;
  logic [N-1:0]          req_all;

  darb_swi_pend #(.SW_N(SW_SRC)) u_swi (
    .clk(clk), .rst(rst), .set_i(sw_set), .clr_i(sw_clr), .pend_o(sw_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) periph_q <= '0;
    else     periph_q <= periph_req;
  end

  assign req_all = {periph_q, sw_pend};

  logic [PRIO_W-1:0] cur_a   [CPU_N];
  logic [PRIO_W-1:0] max_a   [CPU_N];
  logic [N-1:0]      hit_a   [CPU_N];
  logic              val_a   [CPU_N];
  logic [PRIO_W-1:0] wpr_a   [CPU_N];
  logic [VEC_W-1:0]  wvec_a  [CPU_N];
  logic              irq_a   [CPU_N];
  logic [VEC_W-1:0]  vec_a   [CPU_N];

  assign cur_a[0] = cur_prio0;
  assign cur_a[1] = cur_prio1;

  for (genvar c = 0; c < CPU_N; c++) begin : g_cpu
    darb_max_stage #(.N(N), .PRIO_W(PRIO_W), .CPU_ID(c[0])) u_max (
      .clk(clk), .rst(rst), .req_i(req_all), .prio_i(src_prio),
      .route_i(src_cpu), .max_q(max_a[c]), .hit_q(hit_a[c])
    );
    darb_pick_stage #(.N(N), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_pick (
      .clk(clk), .rst(rst), .hit_i(hit_a[c]), .max_i(max_a[c]),
      .valid_q(val_a[c]), .prio_q(wpr_a[c]), .vec_q(wvec_a[c])
    );
    darb_cmp_stage #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_cmp (
      .clk(clk), .rst(rst), .valid_i(val_a[c]), .prio_i(wpr_a[c]),
      .vec_i(wvec_a[c]), .cur_i(cur_a[c]), .irq_o(irq_a[c]), .vec_o(vec_a[c])
    );

    // R1: a raised request names an existing source
    p_vec_range_r1: assert property (@(posedge clk) disable iff (rst)
      irq_a[c] |-> (int'(vec_a[c]) < N));

    // R8: idle processors see vector zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !irq_a[c] |-> (vec_a[c] == '0));
  end

  assign irq0 = irq_a[0];
  assign vec0 = vec_a[0];
  assign irq1 = irq_a[1];
  assign vec1 = vec_a[1];

  // R10: outputs are clear on the first cycle after a reset edge
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (!irq0 && !irq1 && vec0 == '0 && vec1 == '0));
endmodule

// File: tb/test_darb_top.sv
module test_darb_top;
  localparam int NP = 24;
  localparam int N  = 8 + NP;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]     sw_set = '0, sw_clr = '0;
  logic [NP-1:0]  periph_req = '0;
  logic [N*PW-1:0] src_prio = '0;
  logic [N-1:0]   src_cpu = '0;
  logic [PW-1:0]  cur_prio0 = '0, cur_prio1 = '0;
  logic irq0, irq1;
  logic [8:0] vec0, vec1;

  always #10 clk = ~clk;

  darb_top #(.NUM_PERIPH(NP)) i_darb_top (
    .clk(clk), .rst(rst), .sw_set(sw_set), .sw_clr(sw_clr),
    .periph_req(periph_req), .src_prio(src_prio), .src_cpu(src_cpu),
    .cur_prio0(cur_prio0), .cur_prio1(cur_prio1),
    .irq0(irq0), .vec0(vec0), .irq1(irq1), .vec1(vec1)
  );

  int checks = 0, failures = 0;
  string tag = "R3";

  logic [7:0]      sw_m;
  logic [N-1:0]    h_req [4];
  logic [N*PW-1:0] h_prio [4];
  logic [N-1:0]    h_tgt [4];
  logic            e_irq [2];
  logic [8:0]      e_vec [2];

  function automatic logic [9:0] model(logic [N-1:0] rq, logic [N*PW-1:0] pr,
                                       logic [N-1:0] tg, logic [PW-1:0] cur, bit cpu);
    int best = -1;
    int bp = 0;
    for (int i = 0; i < N; i++)
      if (rq[i] && tg[i] == cpu && (best < 0 || int'(pr[i*PW +: PW]) > bp)) begin
        best = i;
        bp = int'(pr[i*PW +: PW]);
      end
    if (best >= 0 && bp > int'(cur)) return {1'b1, 9'(best)};
    return 10'd0;
  endfunction

  task automatic chk(bit ok, string t, int act, int ex);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, ex, $time);
    end
  endtask

  task automatic model_edge();
    logic [9:0] r;
    for (int k = 3; k > 0; k--) begin
      h_req[k] = h_req[k-1]; h_prio[k] = h_prio[k-1]; h_tgt[k] = h_tgt[k-1];
    end
    if (rst) begin
      sw_m = '0;
      h_req[0] = '0;
    end else begin
      sw_m = (sw_m & ~sw_clr) | sw_set;
      h_req[0] = {periph_req, sw_m};
    end
    h_prio[0] = src_prio; h_tgt[0] = src_cpu;
    r = model(h_req[3], h_prio[2], h_tgt[2], cur_prio0, 1'b0);
    e_irq[0] = r[9]; e_vec[0] = r[8:0];
    r = model(h_req[3], h_prio[2], h_tgt[2], cur_prio1, 1'b1);
    e_irq[1] = r[9]; e_vec[1] = r[8:0];
    if (rst) begin e_irq[0] = 0; e_vec[0] = 0; e_irq[1] = 0; e_vec[1] = 0; end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(irq0 === e_irq[0], {tag, " irq0"}, int'(irq0), int'(e_irq[0]));
    chk(vec0 === e_vec[0], {tag, " vec0"}, int'(vec0), int'(e_vec[0]));
    chk(irq1 === e_irq[1], {tag, " irq1"}, int'(irq1), int'(e_irq[1]));
    chk(vec1 === e_vec[1], {tag, " vec1"}, int'(vec1), int'(e_vec[1]));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    sw_set = '0; sw_clr = '0; periph_req = '0; src_prio = '0; src_cpu = '0;
    cur_prio0 = '0; cur_prio1 = '0;
    rst = 1'b1;
    steps(5);
    rst = 1'b0;
  endtask

  task automatic setp(int idx, int p, bit cpu);
    src_prio[idx*PW +: PW] = PW'(p);
    src_cpu[idx] = cpu;
  endtask

  // pulse a set strobe, then return how many edges until irq0 rises
  task automatic pulse_and_time(int sw, output int lat);
    lat = -1;
    sw_set[sw] = 1'b1;
    step();
    sw_set = '0;
    if (irq0) lat = 1;
    for (int k = 2; k <= 8; k++) begin
      if (lat < 0) begin
        step();
        if (irq0) lat = k;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int lat;
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) begin h_req[k] = '0; h_prio[k] = '0; h_tgt[k] = '0; end
    sw_m = '0;
    tag = "R10";
    do_reset();
    step();
    chk(irq0 == 0 && vec0 == 0 && irq1 == 0 && vec1 == 0, "R10 reset outputs",
        int'(irq0) + int'(irq1), 0);

    // R7: software set latency
    tag = "R7";
    setp(2, 9, 0);
    pulse_and_time(2, lat);
    chk(lat == 4, "R7 set-to-irq latency", lat, 4);
    chk(vec0 == 9'd2, "R1 software vector", int'(vec0), 2);

    // R7: peripheral latency, peripheral 3 is vector 11
    do_reset();
    setp(11, 5, 0);
    periph_req[3] = 1'b1;
    lat = -1;
    for (int k = 1; k <= 8; k++) begin
      step();
      if (irq0 && lat < 0) lat = k;
    end
    chk(lat == 4, "R7 periph-to-irq latency", lat, 4);
    chk(vec0 == 9'd11, "R1 peripheral vector", int'(vec0), 11);

    // R9: set wins over clear in the same cycle
    tag = "R9";
    do_reset();
    setp(4, 6, 0);
    sw_set[4] = 1'b1; sw_clr[4] = 1'b1;
    step();
    sw_set = '0; sw_clr = '0;
    steps(4);
    chk(irq0 && vec0 == 9'd4, "R9 set beats clear", int'(vec0), 4);
    sw_clr[4] = 1'b1;
    step();
    sw_clr = '0;
    steps(4);
    chk(!irq0, "R9 clear drops pending", int'(irq0), 0);
    chk(vec0 == 0, "R8 idle vector zero", int'(vec0), 0);

    // R4: earlier higher vector loses to later lower vector at equal priority
    tag = "R4";
    do_reset();
    setp(9, 7, 0); setp(5, 7, 0);
    periph_req[1] = 1'b1;
    steps(6);
    chk(irq0 && vec0 == 9'd9, "R4 single candidate", int'(vec0), 9);
    sw_set[5] = 1'b1;
    step();
    sw_set = '0;
    steps(5);
    chk(irq0 && vec0 == 9'd5, "R4 tie goes to lowest vector", int'(vec0), 5);

    // R2: route sw5 to processor 1
    tag = "R2";
    setp(5, 7, 1);
    steps(5);
    chk(vec0 == 9'd9, "R2 cpu0 keeps peripheral", int'(vec0), 9);
    chk(irq1 && vec1 == 9'd5, "R2 cpu1 gets routed source", int'(vec1), 5);

    // R5: equal current priority blocks; R3: higher priority wins
    tag = "R5";
    cur_prio0 = 4'd7;
    steps(2);
    chk(!irq0, "R5 equal to current does not interrupt", int'(irq0), 0);
    cur_prio0 = 4'd6;
    steps(2);
    chk(irq0 && vec0 == 9'd9, "R5 above current interrupts", int'(vec0), 9);
    tag = "R3";
    setp(20, 12, 0);
    periph_req[12] = 1'b1;
    steps(5);
    chk(irq0 && vec0 == 9'd20, "R3 higher priority wins", int'(vec0), 20);

    // R6: priority zero never interrupts
    tag = "R6";
    do_reset();
    periph_req = '1;
    sw_set = '1;
    step();
    sw_set = '0;
    steps(6);
    chk(!irq0 && !irq1, "R6 priority zero silent", int'(irq0) + int'(irq1), 0);

    // random phase: R3, R2, R5
    tag = "R3";
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      if (c % 40 == 0)
        for (int i = 0; i < N; i++) setp(i, int'($urandom_range(15)), 1'($urandom_range(1)));
      for (int i = 0; i < NP; i++) periph_req[i] = ($urandom_range(3) == 0);
      for (int i = 0; i < 8; i++) begin
        sw_set[i] = ($urandom_range(7) == 0);
        sw_clr[i] = ($urandom_range(7) == 0);
      end
      if (c % 7 == 0) begin
        cur_prio0 = PW'($urandom_range(15));
        cur_prio1 = PW'($urandom_range(15));
      end
      step();
    end

    // tie-heavy phase: R4
    tag = "R4";
    for (int c = 0; c < 1500; c++) begin
      if (c % 50 == 0) begin
        int pv = int'($urandom_range(1, 15));
        for (int i = 0; i < N; i++) setp(i, pv, 1'($urandom_range(1)));
        cur_prio0 = PW'($urandom_range(3));
        cur_prio1 = PW'($urandom_range(3));
      end
      for (int i = 0; i < NP; i++) periph_req[i] = ($urandom_range(5) == 0);
      for (int i = 0; i < 8; i++) begin
        sw_set[i] = ($urandom_range(9) == 0);
        sw_clr[i] = ($urandom_range(9) == 0);
      end
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule